// File: doc/BRIEF.md
# Transceiver attribute command handshake engine

This block carries one configuration command from a host to one channel of a transceiver. The command is held in a register pair on a memory-mapped bus. The host presents a channel index, a 16-bit data value, a set/get flag, a reset flag, a physical lane and an 8-bit opcode, then pulses `start_i`. The block packs these into a 32-bit command word and runs a four-phase handshake as bus master:

1. It writes the word with the request bit set.
2. It polls the status register until the acknowledge bit is 1.
3. It writes the word again with the request bit cleared.
4. It polls until the acknowledge bit is 0.

When the sequence ends, the block returns the last status word and pulses `done_o`. Each poll phase has a limit on the number of reads. If an acknowledge does not arrive within that limit, the run is aborted and `timeout_o` is raised together with `done_o`.

Typical commands are as follows. Loopback uses opcode 0x40 with data 0x6 (serial), 0x4 (TX-to-RX parallel), 0x3 (RX-to-TX parallel) or 0x0 (off). Polarity uses opcode 0x65 (TX) or 0x66 (RX), with data 0x1 to invert and 0x0 for normal polarity. The block does not interpret opcodes.

Top module: `xcvr_attr_engine`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `timeout_o`, `mm_write_o` and `mm_read_o` are all 0.
- R2: The written command word has this layout:
  - bits [31:16] are `data_i`;
  - bit 15 is the request flag;
  - bit 14 is `rst_flag_i`;
  - bit 13 is `set_i` (1 = set, 0 = get);
  - bit 12 is 0;
  - bits [11:10] are 0 and bits [9:8] are `lane_i`;
  - bits [7:0] are `opcode_i`.
- R3: For channel n, the request register is at 0x000A403C + n*0x00100000 and the status register is at 0x000A4040 + n*0x00100000.
- R4: The bus traffic of one command is, in order:
  - one write with bit 15 = 1;
  - one or more reads of the status register;
  - one write with bit 15 = 0;
  - one or more status reads.

  Nothing else is issued, and the bus is quiet whenever `busy_o` is 0.
- R5: The first poll phase ends on the first read whose bit 15 is 1. The second poll phase ends on the first read whose bit 15 is 0.
- R6: Each poll phase issues at most L reads, where L is `poll_limit_i` sampled at start (0 counts as 1). When L reads pass without the awaited value, the run stops with no further access. `done_o` and `timeout_o` are both 1 for one cycle, and `status_o` holds the last read word.
- R7: `done_o` is a one-cycle pulse. It appears two clock edges after the edge that takes in the final read data.
- R8: A write or read stays asserted, with stable address and data, until the edge at which `mm_waitrequest_i` is 0. Write and read are never asserted together.
- R9: Read data is taken only in a cycle with `mm_readdatavalid_i` high. `status_o` equals the last valid read word.
- R10: `start_i` is ignored while `busy_o` is 1. It causes no extra bus access and no extra `done_o`.
- R11: `mm_write_o` rises two clock edges after the edge that samples `start_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start a command (taken only when idle) |
| chan_i | input | 3 | Channel index 0..7 |
| data_i | input | 16 | Command data field |
| set_i | input | 1 | 1 = set, 0 = get |
| rst_flag_i | input | 1 | Reset flag placed in bit 14 |
| lane_i | input | 2 | Physical lane 0..3 |
| opcode_i | input | 8 | Command opcode |
| poll_limit_i | input | 16 | Maximum reads per poll phase (0 acts as 1) |
| busy_o | output | 1 | A command is in progress |
| done_o | output | 1 | One-cycle completion pulse |
| timeout_o | output | 1 | Abort on poll limit, valid with done_o |
| status_o | output | 32 | Last status word read |
| mm_addr_o | output | 32 | Bus address |
| mm_write_o | output | 1 | Bus write request |
| mm_read_o | output | 1 | Bus read request |
| mm_wdata_o | output | 32 | Bus write data |
| mm_waitrequest_i | input | 1 | Slave stall |
| mm_readdata_i | input | 32 | Bus read data |
| mm_readdatavalid_i | input | 1 | Read data valid |

## Verification
Two results have fixed timing:
- The first write rises two edges after the edge that samples `start_i` (R11).
- `done_o` rises two edges after the edge that takes in the final read word (R7).

The bench keeps a cycle counter. It records the cycle in which it drove `start_i` and the cycle in which it drove `mm_readdatavalid_i`. It then compares those against the cycle in which it sees the write, or the done pulse, at the falling edge.

Bus accesses are logged at the falling edge, in the cycle where the responder drops waitrequest. Each is compared in order against the scoreboard queue. The responder inserts waitrequest stalls and read latency, and drives inverted data while read data is not valid. As a result, an early acceptance or capture shows up as a mismatch.

// File: rtl/xcvr_attr_pkg.sv
package xcvr_attr_pkg;

  localparam int unsigned REQ_BIT  = 15;
  localparam int unsigned ACK_BIT  = 15;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SET_WR,
    ST_SET_POLL,
    ST_CLR_WR,
    ST_CLR_POLL
  } seq_state_e;

  typedef enum logic [1:0] {
    AC_IDLE,
    AC_CMD,
    AC_RESP
  } acc_state_e;

  function automatic logic [31:0] pack_word(
    input logic [15:0] data,
    input logic        req,
    input logic        rst_flag,
    input logic        set_flag,
    input logic [3:0]  lane,
    input logic [7:0]  opcode
  );
    return {data, req, rst_flag, set_flag, 1'b0, lane, opcode};
  endfunction

endpackage

// File: rtl/xcvr_attr_addr.sv
module xcvr_attr_addr #(
  parameter int unsigned N_CHAN      = 8,
  parameter int unsigned CHAN_W      = 3,
  parameter logic [31:0] REQ_BASE    = 32'h000A_403C,
  parameter logic [31:0] STAT_BASE   = 32'h000A_4040,
  parameter logic [31:0] CHAN_STRIDE = 32'h0010_0000
) (
  input  logic [CHAN_W-1:0] chan_i,
  output logic [31:0]       req_addr_o,
  output logic [31:0]       stat_addr_o
);

  logic [31:0] req_tab  [N_CHAN];
  logic [31:0] stat_tab [N_CHAN];

  for (genvar c = 0; c < N_CHAN; c++) begin : g_chan
    localparam logic [31:0] OFFS = 32'(c) * CHAN_STRIDE;
    assign req_tab[c]  = REQ_BASE + OFFS;
    assign stat_tab[c] = STAT_BASE + OFFS;
  end

  assign req_addr_o  = req_tab[chan_i];
  assign stat_addr_o = stat_tab[chan_i];

endmodule

// File: rtl/xcvr_attr_mm.sv
module xcvr_attr_mm #(
  parameter int unsigned AW = 32,
  parameter int unsigned DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          go_i,
  input  logic          wr_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic          done_o,
  output logic [DW-1:0] rdata_o,
  output logic [AW-1:0] mm_addr_o,
  output logic          mm_write_o,
  output logic          mm_read_o,
  output logic [DW-1:0] mm_wdata_o,
  input  logic          mm_waitrequest_i,
  input  logic [DW-1:0] mm_readdata_i,
  input  logic          mm_readdatavalid_i
);
  import xcvr_attr_pkg::*;

  acc_state_e    st_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q, rdata_q;
  logic          wr_q, rd_q, done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= AC_IDLE;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      wr_q    <= 1'b0;
      rd_q    <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        AC_IDLE: if (go_i) begin
          addr_q  <= addr_i;
          wdata_q <= wdata_i;
          wr_q    <= wr_i;
          rd_q    <= !wr_i;
          st_q    <= AC_CMD;
        end
        AC_CMD: if (!mm_waitrequest_i) begin
          wr_q <= 1'b0;
          rd_q <= 1'b0;
          if (wr_q) begin
            done_q <= 1'b1;
            st_q   <= AC_IDLE;
          end else begin
            st_q <= AC_RESP;
          end
        end
        AC_RESP: if (mm_readdatavalid_i) begin
          rdata_q <= mm_readdata_i;
          done_q  <= 1'b1;
          st_q    <= AC_IDLE;
        end
        default: st_q <= AC_IDLE;
      endcase
    end
  end

  assign mm_addr_o  = addr_q;
  assign mm_wdata_o = wdata_q;
  assign mm_write_o = wr_q;
  assign mm_read_o  = rd_q;
  assign done_o     = done_q;
  assign rdata_o    = rdata_q;

  p_excl_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mm_write_o && mm_read_o));

  p_hold_wr_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mm_write_o && mm_waitrequest_i) |=>
      (mm_write_o && $stable(mm_addr_o) && $stable(mm_wdata_o)));

  p_hold_rd_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mm_read_o && mm_waitrequest_i) |=> (mm_read_o && $stable(mm_addr_o)));

endmodule

// File: rtl/xcvr_attr_seq.sv
module xcvr_attr_seq #(
  parameter int unsigned CHAN_W  = 3,
  parameter int unsigned LIMIT_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [CHAN_W-1:0]  chan_i,
  input  logic [15:0]        data_i,
  input  logic               set_i,
  input  logic               rst_flag_i,
  input  logic [1:0]         lane_i,
  input  logic [7:0]         opcode_i,
  input  logic [LIMIT_W-1:0] poll_limit_i,
  input  logic               acc_done_i,
  input  logic [31:0]        acc_rdata_i,
  output logic               acc_go_o,
  output logic               acc_wr_o,
  output logic [31:0]        acc_wdata_o,
  output logic [CHAN_W-1:0]  chan_o,
  output logic               busy_o,
  output logic               done_o,
  output logic               timeout_o,
  output logic [31:0]        status_o
);
  import xcvr_attr_pkg::*;

  seq_state_e         state_q;
  logic [31:0]        word_q, status_q;
  logic [CHAN_W-1:0]  chan_q;
  logic [LIMIT_W-1:0] limit_q, tries_q, tries_nxt;
  logic               go_q, done_q, tmo_q, acked;

  assign tries_nxt = tries_q + 1'b1;
  // awaited acknowledge level depends on the phase
  assign acked = (state_q == ST_SET_POLL) ? acc_rdata_i[ACK_BIT] : !acc_rdata_i[ACK_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      word_q   <= '0;
      status_q <= '0;
      chan_q   <= '0;
      limit_q  <= '0;
      tries_q  <= '0;
      go_q     <= 1'b0;
      done_q   <= 1'b0;
      tmo_q    <= 1'b0;
    end else begin
      go_q   <= 1'b0;
      done_q <= 1'b0;
      tmo_q  <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          word_q  <= pack_word(data_i, 1'b0, rst_flag_i, set_i, {2'b00, lane_i}, opcode_i);
          chan_q  <= chan_i;
          limit_q <= (poll_limit_i == '0) ? LIMIT_W'(1) : poll_limit_i;
          go_q    <= 1'b1;
          state_q <= ST_SET_WR;
        end
        ST_SET_WR, ST_CLR_WR: if (acc_done_i) begin
          go_q    <= 1'b1;
          tries_q <= '0;
          state_q <= (state_q == ST_SET_WR) ? ST_SET_POLL : ST_CLR_POLL;
        end
        ST_SET_POLL, ST_CLR_POLL: if (acc_done_i) begin
          if (acked) begin
            if (state_q == ST_SET_POLL) begin
              go_q    <= 1'b1;
              state_q <= ST_CLR_WR;
            end else begin
              done_q   <= 1'b1;
              status_q <= acc_rdata_i;
              state_q  <= ST_IDLE;
            end
          end else if (tries_nxt >= limit_q) begin
            done_q   <= 1'b1;
            tmo_q    <= 1'b1;
            status_q <= acc_rdata_i;
            state_q  <= ST_IDLE;
          end else begin
            tries_q <= tries_nxt;
            go_q    <= 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign acc_go_o    = go_q;
  assign acc_wr_o    = (state_q == ST_SET_WR) || (state_q == ST_CLR_WR);
  assign acc_wdata_o = {word_q[31:16], state_q == ST_SET_WR, word_q[14:0]};
  assign chan_o      = chan_q;
  assign busy_o      = (state_q != ST_IDLE);
  assign done_o      = done_q;
  assign timeout_o   = tmo_q;
  assign status_o    = status_q;

  p_tmo_with_done_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |-> done_o);

  p_done_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_ignore_busy_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> ($stable(chan_o) && $stable(limit_q)));

  p_poll_bound_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (tries_q < limit_q || !(state_q == ST_SET_POLL || state_q == ST_CLR_POLL)));

endmodule

// File: rtl/xcvr_attr_engine.sv
module xcvr_attr_engine #(
  parameter int unsigned N_CHAN      = 8,
  parameter int unsigned LIMIT_W     = 16,
  parameter logic [31:0] REQ_BASE    = 32'h000A_403C,
  parameter logic [31:0] STAT_BASE   = 32'h000A_4040,
  parameter logic [31:0] CHAN_STRIDE = 32'h0010_0000,
  localparam int unsigned CHAN_W     = (N_CHAN > 1) ? $clog2(N_CHAN) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [CHAN_W-1:0]  chan_i,
  input  logic [15:0]        data_i,
  input  logic               set_i,
  input  logic               rst_flag_i,
  input  logic [1:0]         lane_i,
  input  logic [7:0]         opcode_i,
  input  logic [LIMIT_W-1:0] poll_limit_i,
  output logic               busy_o,
  output logic               done_o,
  output logic               timeout_o,
  output logic [31:0]        status_o,
  output logic [31:0]        mm_addr_o,
  output logic               mm_write_o,
  output logic               mm_read_o,
  output logic [31:0]        mm_wdata_o,
  input  logic               mm_waitrequest_i,
  input  logic [31:0]        mm_readdata_i,
  input  logic               mm_readdatavalid_i
);

  logic              acc_go, acc_wr, acc_done;
  logic [31:0]       acc_wdata, acc_rdata, req_addr, stat_addr;
  logic [CHAN_W-1:0] chan_q;

  xcvr_attr_seq #(.CHAN_W(CHAN_W), .LIMIT_W(LIMIT_W)) u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_i),
    .chan_i       (chan_i),
    .data_i       (data_i),
    .set_i        (set_i),
    .rst_flag_i   (rst_flag_i),
    .lane_i       (lane_i),
    .opcode_i     (opcode_i),
    .poll_limit_i (poll_limit_i),
    .acc_done_i   (acc_done),
    .acc_rdata_i  (acc_rdata),
    .acc_go_o     (acc_go),
    .acc_wr_o     (acc_wr),
    .acc_wdata_o  (acc_wdata),
    .chan_o       (chan_q),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .timeout_o    (timeout_o),
    .status_o     (status_o)
  );

  xcvr_attr_addr #(
    .N_CHAN(N_CHAN), .CHAN_W(CHAN_W), .REQ_BASE(REQ_BASE),
    .STAT_BASE(STAT_BASE), .CHAN_STRIDE(CHAN_STRIDE)
  ) u_addr (
    .chan_i      (chan_q),
    .req_addr_o  (req_addr),
    .stat_addr_o (stat_addr)
  );

  xcvr_attr_mm #(.AW(32), .DW(32)) u_mm (
    .clk_i              (clk_i),
    .rst_ni             (rst_ni),
    .go_i               (acc_go),
    .wr_i               (acc_wr),
    .addr_i             (acc_wr ? req_addr : stat_addr),
    .wdata_i            (acc_wdata),
    .done_o             (acc_done),
    .rdata_o            (acc_rdata),
    .mm_addr_o          (mm_addr_o),
    .mm_write_o         (mm_write_o),
    .mm_read_o          (mm_read_o),
    .mm_wdata_o         (mm_wdata_o),
    .mm_waitrequest_i   (mm_waitrequest_i),
    .mm_readdata_i      (mm_readdata_i),
    .mm_readdatavalid_i (mm_readdatavalid_i)
  );

  p_quiet_idle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !(mm_write_o || mm_read_o));

  p_rsvd_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mm_write_o |-> (mm_wdata_o[12:10] == 3'b000));

  p_no_done_busy_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

endmodule

// File: tb/tb_xcvr_attr_engine.sv
module tb_xcvr_attr_engine;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    int          kind;   // 1 write, 2 read, 3 result
    logic [31:0] addr;
    logic [31:0] data;
    logic        tmo;
  } exp_t;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        start = 1'b0, set_f = 1'b0, rflag = 1'b0;
  logic [2:0]  chan = '0;
  logic [15:0] data = '0, limit = '0;
  logic [1:0]  lane = '0;
  logic [7:0]  opc = '0;
  logic        busy, done, tmo;
  logic [31:0] status, mm_addr, mm_wdata;
  logic        mm_write, mm_read;
  logic        wreq = 1'b1, rdv = 1'b0;
  logic [31:0] rdata = '0;

  int checks = 0, fails = 0, cyc = 0;
  int cfg_wait = 0, cfg_lat = 1, cfg_nset = 0, cfg_nclr = 0;
  int wcnt = 0, rd_lat = 0, rd_idx = 0, last_rdv_cyc = 0, start_cyc = 0;
  bit rd_pend = 0, req_state = 0, first_pend = 0, done_seen = 0;
  bit hold_prev = 0;
  logic [31:0] pend_val = '0, prev_addr = '0;
  exp_t q[$];

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  xcvr_attr_engine dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .chan_i(chan), .data_i(data),
    .set_i(set_f), .rst_flag_i(rflag), .lane_i(lane), .opcode_i(opc),
    .poll_limit_i(limit), .busy_o(busy), .done_o(done), .timeout_o(tmo),
    .status_o(status), .mm_addr_o(mm_addr), .mm_write_o(mm_write),
    .mm_read_o(mm_read), .mm_wdata_o(mm_wdata), .mm_waitrequest_i(wreq),
    .mm_readdata_i(rdata), .mm_readdatavalid_i(rdv)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h @cyc %0d", tag, act, exp, cyc);
    end
  endtask

  function automatic logic [31:0] sval(input int ch, input bit ack, input int idx);
    return {12'hA50, 1'b0, 3'(ch), ack, 15'(idx)};
  endfunction

  function automatic exp_t mk(input int k, input logic [31:0] a, input logic [31:0] d, input logic t);
    exp_t e;
    e.kind = k; e.addr = a; e.data = d; e.tmo = t;
    return e;
  endfunction

  // responder and monitor
  always @(negedge clk) begin
    if (!rst_n) begin
      wreq = 1'b1; rdv = 1'b0; rd_pend = 0; wcnt = cfg_wait; hold_prev = 0;
    end else begin
      rdv = 1'b0;
      rdata = ~pend_val;
      if (rd_pend) begin
        if (rd_lat > 1) rd_lat--;
        else begin
          rdv = 1'b1; rdata = pend_val; rd_pend = 0; last_rdv_cyc = cyc;
        end
      end
      if (hold_prev) chk((mm_write || mm_read) && mm_addr == prev_addr, "R8 hold", mm_addr, prev_addr);
      hold_prev = 0;
      if (mm_write && mm_read) chk(0, "R8 excl", 32'(mm_read), 0);
      if (first_pend && mm_write) begin
        chk(cyc == start_cyc + 2, "R11 start latency", 32'(cyc), 32'(start_cyc + 2));
        first_pend = 0;
      end
      if (mm_write || mm_read) begin
        if (wcnt > 0) begin
          wreq = 1'b1; wcnt--; hold_prev = 1; prev_addr = mm_addr;
        end else begin
          wreq = 1'b0; wcnt = cfg_wait;
          if (q.size() == 0) chk(0, "R4 unexpected access", mm_addr, 0);
          else begin
            exp_t e;
            e = q.pop_front();
            if (mm_write) begin
              chk(e.kind == 1, "R4 order", 32'(1), 32'(e.kind));
              chk(mm_addr == e.addr, "R3 req addr", mm_addr, e.addr);
              chk(mm_wdata == e.data, "R2 word", mm_wdata, e.data);
              req_state = mm_wdata[15]; rd_idx = 0;
            end else begin
              bit ack;
              chk(e.kind == 2, "R5 order", 32'(2), 32'(e.kind));
              chk(mm_addr == e.addr, "R3 stat addr", mm_addr, e.addr);
              ack = req_state ? (rd_idx >= cfg_nset) : (rd_idx < cfg_nclr);
              pend_val = sval(int'(mm_addr[22:20]), ack, rd_idx);
              rd_idx++; rd_pend = 1; rd_lat = cfg_lat;
            end
          end
        end
      end else begin
        wreq = 1'b1; wcnt = cfg_wait;
      end
      if (done) begin
        if (q.size() == 0) chk(0, "R10 extra done", 32'(1), 0);
        else begin
          exp_t e;
          e = q.pop_front();
          chk(e.kind == 3, "R4 early done", 32'(3), 32'(e.kind));
          chk(status == e.data, "R9 status", status, e.data);
          chk(tmo == e.tmo, "R6 timeout flag", 32'(tmo), 32'(e.tmo));
          chk(cyc == last_rdv_cyc + 2, "R7 done latency", 32'(cyc), 32'(last_rdv_cyc + 2));
        end
        done_seen = 1;
      end
    end
  end

  task automatic run_cmd(input int ch, input logic [15:0] d, input bit s, input bit rf,
                         input int ln, input logic [7:0] op, input int lim_in,
                         input int nset, input int nclr, input int wt, input int lat, input bit ign);
    logic [31:0] w1, ra, sa;
    int lim;
    lim = (lim_in == 0) ? 1 : lim_in;
    ra = 32'h000A403C + 32'(ch) * 32'h00100000;
    sa = 32'h000A4040 + 32'(ch) * 32'h00100000;
    w1 = {d, 1'b1, rf, s, 1'b0, 2'b00, 2'(ln), op};
    cfg_wait = wt; cfg_lat = lat; cfg_nset = nset; cfg_nclr = nclr;
    q.push_back(mk(1, ra, w1, 0));
    if (nset + 1 > lim) begin
      for (int i = 0; i < lim; i++) q.push_back(mk(2, sa, 0, 0));
      q.push_back(mk(3, 0, sval(ch, 0, lim - 1), 1));
    end else begin
      for (int i = 0; i <= nset; i++) q.push_back(mk(2, sa, 0, 0));
      q.push_back(mk(1, ra, {w1[31:16], 1'b0, w1[14:0]}, 0));
      if (nclr + 1 > lim) begin
        for (int i = 0; i < lim; i++) q.push_back(mk(2, sa, 0, 0));
        q.push_back(mk(3, 0, sval(ch, 1, lim - 1), 1));
      end else begin
        for (int i = 0; i <= nclr; i++) q.push_back(mk(2, sa, 0, 0));
        q.push_back(mk(3, 0, sval(ch, 0, nclr), 0));
      end
    end
    @(negedge clk);
    done_seen = 0;
    start = 1; chan = 3'(ch); data = d; set_f = s; rflag = rf; lane = 2'(ln); opc = op;
    limit = 16'(lim_in); start_cyc = cyc; first_pend = 1;
    @(negedge clk);
    start = 0;
    if (ign) begin
      repeat (4) @(negedge clk);
      chk(busy, "R10 busy before stray start", 32'(busy), 1);
      start = 1; chan = 3'(ch ^ 1); opc = 8'h40; data = 16'h6;
      @(negedge clk);
      start = 0;
    end
    while (!done_seen) @(negedge clk);
    repeat (6) @(negedge clk);
    chk(q.size() == 0, ign ? "R10 leftover" : "R4 leftover", 32'(q.size()), 0);
    chk(!busy && !mm_write && !mm_read, ign ? "R10 idle" : "R4 idle", 32'(busy), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !done && !tmo && !mm_write && !mm_read, "R1 reset", 32'({busy, done, tmo, mm_write, mm_read}), 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk(!busy && !mm_write && !mm_read, "R1 after release", 32'({busy, mm_write, mm_read}), 0);
    // serial loopback, polls in both phases
    run_cmd(0, 16'h6, 1, 0, 1, 8'h40, 8, 2, 1, 0, 1, 0);
    // RX polarity invert, stalls and read latency
    run_cmd(7, 16'h1, 1, 0, 3, 8'h66, 4, 0, 0, 2, 3, 0);
    // get with reset flag, ack on the last allowed read in both phases
    run_cmd(3, 16'h0, 0, 1, 2, 8'h40, 5, 4, 4, 1, 2, 0);
    // R6 timeout in first phase
    run_cmd(5, 16'h4, 1, 0, 0, 8'h40, 3, 3, 0, 0, 1, 0);
    // R6 timeout in second phase
    run_cmd(2, 16'h3, 1, 0, 1, 8'h40, 2, 1, 2, 1, 1, 0);
    // R6 limit 0 acts as 1
    run_cmd(4, 16'h0, 1, 0, 0, 8'h65, 0, 0, 0, 0, 1, 0);
    run_cmd(6, 16'h1, 1, 0, 2, 8'h65, 0, 1, 0, 0, 1, 0);
    // R10 stray start while busy
    run_cmd(1, 16'h1, 1, 0, 3, 8'h65, 6, 3, 2, 1, 2, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired at cyc %0d", cyc);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule